// File: doc/BRIEF.md
# Accumulator-Memory Exchange Unit

This unit swaps part of an accumulator with one word of data memory, running beside an arithmetic operation of the same instruction. The instruction gives a destination accumulator through a one-bit select. The unit always works on the other accumulator, called the target. A width select chooses either the full target or only its low 16 bits. The unit keeps the chosen part in a temporary register. It reads the memory word at one of four pointer registers and loads that word into the same part of the target. It then steps the pointer by a chosen action, writes the temporary back at the new pointer value, and increments the pointer.

The unit owns the four 16-bit pointers and the two 36-bit accumulators. Each of these can be loaded from the host side while the unit is idle. The data memory is single-port and synchronous: its read data arrives one cycle after the read strobe. A separate source select names the accumulator that the arithmetic operation reads. The unit captures that accumulator when the swap starts, so the arithmetic always sees the value from before the swap, even when the source is the target.

Top module: `acc_mem_swap`

## Requirements
- R1: While reset is active, and after it is released, both accumulators and all four pointers read zero, and `done_o`, `mem_rd_o` and `mem_wr_o` are low.
- R2: `d_i`=0 makes accumulator 1 the target and `d_i`=1 makes accumulator 0 the target. The non-target accumulator keeps its value through the swap.
- R3: `z_i[3:2]` chooses the pointer: 0 gives pointer 0, 1 gives pointer 1, 2 gives pointer 2, 3 gives pointer 3. The other three pointers are not changed.
- R4: `z_i[1:0]` chooses the first pointer step: 0 leaves the pointer as it is, 1 adds one, 2 subtracts one, 3 adds `idx_i`. All steps are modulo 2^16.
- R5: The write goes to the pointer value after the first step. After the write, the pointer is incremented by one, modulo 2^16.
- R6: With `x_i`=0, the word written to memory is target bits 15:0. The loaded word replaces only target bits 15:0, and bits 35:16 are kept.
- R7: With `x_i`=1, the word written to memory is target bits 31:16. The target becomes the loaded word in bits 31:16, the sign of that word copied into bits 35:32, and zeros in bits 15:0.
- R8: Take a start accepted at clock edge E0. The read strobe is high in the cycle after E0. The write strobe is high in the following cycle. `done_o` is high for the single cycle after that. The two strobes are never high together.
- R9: `operand_o` holds the value the source accumulator (`src_i`=0 gives accumulator 0, 1 gives accumulator 1) had at the accepted start, not the value after the swap.
- R10: A start seen while a swap is in progress is ignored: it causes no extra memory access or pointer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a swap (taken only when idle) |
| z_i | input | 4 | Pointer choice [3:2] and first step action [1:0] |
| x_i | input | 1 | 0: low half, 1: full accumulator |
| d_i | input | 1 | Destination select; the target is the other accumulator |
| src_i | input | 1 | Accumulator read by the arithmetic operation |
| idx_i | input | 16 | Index added by step action 3 |
| acc_we_i | input | 1 | Host accumulator write (idle only) |
| acc_sel_i | input | 1 | Accumulator to write |
| acc_val_i | input | 36 | Accumulator write value |
| ptr_we_i | input | 1 | Host pointer write (idle only) |
| ptr_sel_i | input | 2 | Pointer to write |
| ptr_val_i | input | 16 | Pointer write value |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the read strobe |
| acc0_o | output | 36 | Accumulator 0 |
| acc1_o | output | 36 | Accumulator 1 |
| ptr_o | output | 64 | Pointers, pointer n in bits 16n+15:16n |
| operand_o | output | 36 | Pre-swap source accumulator value |
| done_o | output | 1 | One-cycle pulse when the swap completes |

## Verification
Counting from the edge that accepts the start, the read strobe and its address are due one cycle later. The write strobe, the stepped address and the saved word are due two cycles later. The loaded accumulator, the final pointer, the written memory word and the `done_o` pulse are due three cycles later. The bench drives inputs on falling edges and samples each result on the falling edge inside its own cycle: one, two and three cycles after the start, and a fourth time to see `done_o` drop. A single loop runs over a table of swap vectors, and expected values are worked out from the requirement text. Directed cases follow for reset and for a start held high through a whole swap.

// File: rtl/acc_swap_pkg.sv
package acc_swap_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ACC_W   = 36;
  localparam int unsigned GUARD_W = ACC_W - 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ACC_W-1:0]  acc_t;

  typedef enum logic [1:0] {
    STEP_KEEP = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_IDX  = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_WRITE = 2'b10
  } swap_state_e;

  // Pointer update for one step action, modulo 2^WORD_W
  function automatic word_t step_ptr(word_t p, logic [1:0] code, word_t idx);
    word_t r;
    unique case (code)
      STEP_KEEP: r = p;
      STEP_INC:  r = p + word_t'(1);
      STEP_DEC:  r = p - word_t'(1);
      default:   r = p + idx;
    endcase
    return r;
  endfunction

  // Part of an accumulator that gets parked and written to memory
  function automatic word_t save_word(acc_t a, logic full);
    return full ? a[2*WORD_W-1:WORD_W] : a[WORD_W-1:0];
  endfunction

  // Accumulator value after a memory word is loaded into it
  function automatic acc_t load_word(acc_t a, word_t w, logic full);
    acc_t r;
    if (full) r = {{GUARD_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
    else      r = {a[ACC_W-1:WORD_W], w};
    return r;
  endfunction
endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import acc_swap_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W+1:0] z_i,
  input  logic             x_i,
  input  logic             d_i,
  input  acc_t             acc0_i,
  input  acc_t             acc1_i,
  output logic             idle_o,
  output logic             accept_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             step_en_o,
  output logic [1:0]       step_code_o,
  output logic             load_en_o,
  output logic             load_tgt_o,
  output logic             load_full_o,
  output word_t            wdata_o,
  output logic             done_o
);
  swap_state_e      state_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       code_q;
  logic             full_q;
  logic             tgt_q;
  word_t            temp_q;
  logic             done_q;

  assign idle_o   = (state_q == ST_IDLE);
  assign accept_o = start_i && idle_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      code_q  <= '0;
      full_q  <= 1'b0;
      tgt_q   <= 1'b0;
      temp_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_WRITE);
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          sel_q   <= z_i[SEL_W+1:2];
          code_q  <= z_i[1:0];
          full_q  <= x_i;
          tgt_q   <= ~d_i;
          temp_q  <= save_word(d_i ? acc0_i : acc1_i, x_i);
          state_q <= ST_READ;
        end
        ST_READ:  state_q <= ST_WRITE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o        = (state_q == ST_READ);
  assign wr_o        = (state_q == ST_WRITE);
  assign sel_o       = sel_q;
  assign step_en_o   = rd_o || wr_o;
  assign step_code_o = wr_o ? STEP_INC : code_q;
  assign load_en_o   = wr_o;
  assign load_tgt_o  = tgt_q;
  assign load_full_o = full_q;
  assign wdata_o     = temp_q;
  assign done_o      = done_q;

  p_single_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));
  p_read_then_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> wr_o);
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> done_o && !wr_o);
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !idle_o) |=> !rd_o);
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
  import acc_swap_pkg::*;
#(
  parameter int unsigned NPTR  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_we_i,
  input  logic [SEL_W-1:0]         host_sel_i,
  input  word_t                    host_val_i,
  input  logic                     step_en_i,
  input  logic [SEL_W-1:0]         step_sel_i,
  input  logic [1:0]               step_code_i,
  input  word_t                    idx_i,
  output logic [NPTR*WORD_W-1:0]   ptrs_o
);
  word_t regs_q [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (step_en_i && step_sel_i == SEL_W'(g))
        regs_q[g] <= step_ptr(regs_q[g], step_code_i, idx_i);
      else if (host_we_i && host_sel_i == SEL_W'(g))
        regs_q[g] <= host_val_i;
    end
    assign ptrs_o[g*WORD_W +: WORD_W] = regs_q[g];

    p_unselected_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en_i && step_sel_i != SEL_W'(g)) |=> $stable(regs_q[g]));
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank
  import acc_swap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  host_we_i,
  input  logic  host_sel_i,
  input  acc_t  host_val_i,
  input  logic  load_en_i,
  input  logic  load_tgt_i,
  input  logic  load_full_i,
  input  word_t load_word_i,
  output acc_t  acc0_o,
  output acc_t  acc1_o
);
  acc_t acc_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[g] <= '0;
      else if (load_en_i && load_tgt_i == g[0])
        acc_q[g] <= load_word(acc_q[g], load_word_i, load_full_i);
      else if (host_we_i && host_sel_i == g[0])
        acc_q[g] <= host_val_i;
    end

    p_low_load_keeps_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en_i && !load_full_i && load_tgt_i == g[0])
        |=> acc_q[g][ACC_W-1:WORD_W] == $past(acc_q[g][ACC_W-1:WORD_W]));
    p_other_acc_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en_i && load_tgt_i != g[0]) |=> $stable(acc_q[g]));
  end

  assign acc0_o = acc_q[0];
  assign acc1_o = acc_q[1];
endmodule

// File: rtl/acc_mem_swap.sv
module acc_mem_swap
  import acc_swap_pkg::*;
#(
  parameter int unsigned NPTR  = 4,
  localparam int unsigned SEL_W = $clog2(NPTR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [SEL_W+1:0]       z_i,
  input  logic                   x_i,
  input  logic                   d_i,
  input  logic                   src_i,
  input  logic [WORD_W-1:0]      idx_i,
  input  logic                   acc_we_i,
  input  logic                   acc_sel_i,
  input  logic [ACC_W-1:0]       acc_val_i,
  input  logic                   ptr_we_i,
  input  logic [SEL_W-1:0]       ptr_sel_i,
  input  logic [WORD_W-1:0]      ptr_val_i,
  output logic                   mem_rd_o,
  output logic                   mem_wr_o,
  output logic [WORD_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]      mem_wdata_o,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  output logic [ACC_W-1:0]       acc0_o,
  output logic [ACC_W-1:0]       acc1_o,
  output logic [NPTR*WORD_W-1:0] ptr_o,
  output logic [ACC_W-1:0]       operand_o,
  output logic                   done_o
);
  logic             idle, accept, step_en, load_en, load_tgt, load_full;
  logic [SEL_W-1:0] sel;
  logic [1:0]       step_code;
  acc_t             operand_q;

  swap_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .z_i(z_i), .x_i(x_i), .d_i(d_i),
    .acc0_i(acc0_o), .acc1_i(acc1_o), .idle_o(idle), .accept_o(accept),
    .rd_o(mem_rd_o), .wr_o(mem_wr_o), .sel_o(sel), .step_en_o(step_en),
    .step_code_o(step_code), .load_en_o(load_en), .load_tgt_o(load_tgt),
    .load_full_o(load_full), .wdata_o(mem_wdata_o), .done_o(done_o)
  );

  ptr_bank #(.NPTR(NPTR), .SEL_W(SEL_W)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .host_we_i(ptr_we_i && idle), .host_sel_i(ptr_sel_i),
    .host_val_i(ptr_val_i), .step_en_i(step_en), .step_sel_i(sel),
    .step_code_i(step_code), .idx_i(idx_i), .ptrs_o(ptr_o)
  );

  acc_bank accs_i (
    .clk(clk), .rst_n(rst_n), .host_we_i(acc_we_i && idle), .host_sel_i(acc_sel_i),
    .host_val_i(acc_val_i), .load_en_i(load_en), .load_tgt_i(load_tgt),
    .load_full_i(load_full), .load_word_i(mem_rdata_i), .acc0_o(acc0_o), .acc1_o(acc1_o)
  );

  // Arithmetic operand: the source accumulator as it stood when the swap began
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      operand_q <= '0;
    else if (accept) operand_q <= src_i ? acc1_o : acc0_o;
  end
  assign operand_o  = operand_q;
  assign mem_addr_o = ptr_o[sel*WORD_W +: WORD_W];

  p_second_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> ptr_o[sel*WORD_W +: WORD_W] == WORD_W'($past(mem_addr_o) + 1'b1));
  p_operand_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(operand_q));
endmodule

// File: tb/acc_mem_swap_tb_top.sv
`timescale 1ns/1ps
module acc_mem_swap_tb_top;
  localparam int CLK_NS = 20;

  typedef struct packed {
    logic [3:0]  z;
    logic        x;
    logic        d;
    logic        s;
    logic [15:0] ptr;
    logic [15:0] idx;
    logic [35:0] a0;
    logic [35:0] a1;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b0001, 1'b1, 1'b0, 1'b1, 16'h0010, 16'h0000, 36'h0_1111_2222, 36'h0_3333_4444, 16'h8001},
    '{4'b0110, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 36'hF_8765_4321, 36'h0_0000_0005, 16'h5A5A},
    '{4'b1011, 1'b1, 1'b1, 1'b1, 16'h0020, 16'h0005, 36'h0_7FFF_ABCD, 36'h0_0000_0001, 16'h7FFF},
    '{4'b1100, 1'b0, 1'b0, 1'b1, 16'h0040, 16'h1234, 36'h0_2468_ACE0, 36'hA_BCDE_F012, 16'h1357},
    '{4'b1111, 1'b1, 1'b0, 1'b0, 16'h0050, 16'hFFF0, 36'h0_0000_0099, 36'hF_C000_00AA, 16'hFFFF},
    '{4'b0001, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 36'h5_0000_FFFF, 36'h0_1234_5678, 16'h0042}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]  z = '0;
  logic        x = 1'b0, d = 1'b0, s = 1'b0;
  logic [15:0] idx = '0;
  logic        acc_we = 1'b0, acc_sel = 1'b0;
  logic [35:0] acc_val = '0;
  logic        ptr_we = 1'b0;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] ptr_val = '0;
  logic        mem_rd, mem_wr, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [35:0] acc0, acc1, operand;
  logic [63:0] ptrs;
  logic [15:0] mem [256];
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  acc_mem_swap dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .z_i(z), .x_i(x), .d_i(d), .src_i(s),
    .idx_i(idx), .acc_we_i(acc_we), .acc_sel_i(acc_sel), .acc_val_i(acc_val),
    .ptr_we_i(ptr_we), .ptr_sel_i(ptr_sel), .ptr_val_i(ptr_val),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .acc0_o(acc0), .acc1_o(acc1), .ptr_o(ptrs),
    .operand_o(operand), .done_o(done)
  );

  // Synchronous single-port memory model, 256 words
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Restated expectations, written independently of the design
  function automatic logic [15:0] first_step(logic [15:0] p, logic [1:0] c, logic [15:0] i);
    logic [16:0] t;
    if (c == 2'd1) t = {1'b0, p} + 17'd1;
    else if (c == 2'd2) t = {1'b0, p} + 17'h0FFFF;
    else if (c == 2'd3) t = {1'b0, p} + {1'b0, i};
    else t = {1'b0, p};
    return t[15:0];
  endfunction

  function automatic logic [35:0] after_load(logic [35:0] a, logic [15:0] w, logic x_full);
    logic signed [35:0] t;
    if (!x_full) return {a[35:16], w};
    t = $signed(w);
    return 36'(t <<< 16);
  endfunction

  task automatic host_acc(input logic sel, input logic [35:0] v);
    @(negedge clk); acc_we = 1'b1; acc_sel = sel; acc_val = v;
    @(negedge clk); acc_we = 1'b0;
  endtask

  task automatic host_ptr(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk); ptr_we = 1'b1; ptr_sel = sel; ptr_val = v;
    @(negedge clk); ptr_we = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [1:0]  psel;
    logic [35:0] tgt_old, oth_old, tgt_new;
    logic [15:0] temp, wa, pfin, other [4];
    psel = v.z[3:2];
    host_acc(1'b0, v.a0);
    host_acc(1'b1, v.a1);
    for (int i = 0; i < 4; i++) begin
      other[i] = (i == int'(psel)) ? v.ptr : 16'(16'h0100 * (i + 1) + 16'h0003);
      host_ptr(2'(i), other[i]);
    end
    tgt_old = v.d ? v.a0 : v.a1;
    oth_old = v.d ? v.a1 : v.a0;
    temp    = v.x ? tgt_old[31:16] : tgt_old[15:0];
    tgt_new = after_load(tgt_old, v.word, v.x);
    wa      = first_step(v.ptr, v.z[1:0], v.idx);
    pfin    = wa + 16'd1;
    mem[v.ptr[7:0]] = v.word;
    if (wa[7:0] != v.ptr[7:0]) mem[wa[7:0]] = 16'hDEAD;
    @(negedge clk);
    z = v.z; x = v.x; d = v.d; s = v.s; idx = v.idx; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(mem_rd && !mem_wr, "R8 read strobe", {mem_rd, mem_wr}, 2'b10);
    chk(mem_addr == v.ptr, "R3 read address", mem_addr, v.ptr);
    @(negedge clk);
    chk(mem_wr && !mem_rd, "R8 write strobe", {mem_rd, mem_wr}, 2'b01);
    chk(mem_addr == wa, "R4 write address after first step", mem_addr, wa);
    chk(mem_wdata == temp, v.x ? "R7 saved high word" : "R6 saved low word", mem_wdata, temp);
    @(negedge clk);
    chk(done === 1'b1, "R8 done pulse", done, 1);
    chk((v.d ? acc0 : acc1) == tgt_new, v.x ? "R7 full load" : "R6 low load",
        v.d ? acc0 : acc1, tgt_new);
    chk((v.d ? acc1 : acc0) == oth_old, "R2 other accumulator kept", v.d ? acc1 : acc0, oth_old);
    chk(ptrs[psel*16 +: 16] == pfin, "R5 second step increment", ptrs[psel*16 +: 16], pfin);
    chk(mem[wa[7:0]] == temp, "R5 memory written at stepped pointer", mem[wa[7:0]], temp);
    chk(operand == (v.s ? v.a1 : v.a0), "R9 pre-swap operand", operand, v.s ? v.a1 : v.a0);
    for (int i = 0; i < 4; i++)
      if (i != int'(psel))
        chk(ptrs[i*16 +: 16] == other[i], "R3 other pointer kept", ptrs[i*16 +: 16], other[i]);
    @(negedge clk);
    chk(!done && !mem_rd && !mem_wr, "R8 done single cycle", {done, mem_rd, mem_wr}, 3'b000);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i);
    @(negedge clk); @(negedge clk);
    chk(acc0 == 0 && acc1 == 0 && ptrs == 0, "R1 state in reset", {acc0[27:0], ptrs[35:0]}, 0);
    chk(!done && !mem_rd && !mem_wr, "R1 strobes in reset", {done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc0 == 0 && acc1 == 0 && ptrs == 0 && !done, "R1 state after reset",
        {acc1[27:0], ptrs[35:0]}, 0);

    for (int k = 0; k < 6; k++) run_vec(VECS[k]);

    // R10: start held high across an entire swap triggers one swap only
    host_ptr(2'd0, 16'h0070);
    host_acc(1'b1, 36'h0_0000_1234);
    mem[8'h70] = 16'h0ABC;
    @(negedge clk);
    z = 4'b0001; x = 1'b0; d = 1'b0; s = 1'b0; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(!mem_rd, "R10 no second read while busy", mem_rd, 0);
    start = 1'b0;
    @(negedge clk);
    chk(!mem_rd && !mem_wr, "R10 no extra access", {mem_rd, mem_wr}, 0);
    chk(ptrs[15:0] == 16'h0072, "R10 single pointer update", ptrs[15:0], 16'h0072);
    chk(acc1 == 36'h0_0000_0ABC, "R10 single load", acc1, 36'h0_0000_0ABC);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule